// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Carry and Overflow Flags

This block is the integer execution unit of a simple load/store processor. It is purely combinational. It takes two operands of a configurable width and a four-bit operation code drawn from the low bits of the instruction's function field. From these it computes a result word together with a carry flag and a signed-overflow flag. Addition, subtraction and both magnitude compares share one adder. The second operand is inverted and a carry-in of one is injected whenever a difference is needed.

The block has no clock, no register and no handshake. Its outputs follow its inputs within the same cycle. The surrounding datapath presents the operands and the code, and captures the result at its own register stage. Codes that name no operation drive every output low, so a stray code cannot leave stale data on the result bus.

Top module: `flag_alu`

## Requirements
- R1: Codes 4'b0000 and 4'b0001 give y = (a + b) modulo 2^WIDTH.
- R2: Codes 4'b0010 and 4'b0011 give y = (a - b) modulo 2^WIDTH, formed as a + ~b + 1 in the shared adder.
- R3: For the four add/subtract codes, cout is the carry out of the top adder bit. For subtraction this means cout = 1 exactly when a >= b as unsigned numbers.
- R4: For the four add/subtract codes, ov = 1 exactly when the two adder inputs (a and b, or a and ~b) share a sign bit and the sign bit of the result differs from it.
- R5: Code 4'b0100 gives a AND b, 4'b0101 gives a OR b, 4'b0110 gives a XOR b, and 4'b0111 gives NOT (a OR b).
- R6: Code 4'b1010 gives y = 1 when a < b as two's-complement numbers, and y = 0 otherwise. All upper bits of y are zero.
- R7: Code 4'b1011 gives y = 1 when a < b as unsigned numbers, and y = 0 otherwise. All upper bits of y are zero.
- R8: For the logic codes and the two compare codes, cout and ov are both 0.
- R9: Every other code (4'b1000, 4'b1001, 4'b1100 to 4'b1111) gives y = 0, cout = 0 and ov = 0.
- R10: All outputs depend only on the present inputs and settle within the cycle in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| f | input | 4 | Operation code (low bits of the function field) |
| y | output | WIDTH | Result word |
| cout | output | 1 | Carry out of the adder for add/subtract codes |
| ov | output | 1 | Signed overflow for add/subtract codes |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the inputs and y, cout or ov. The bench changes a, b and f a short delay after each rising edge. It compares all three outputs with a behavioural reference at the following falling edge, which leaves half a period for the logic to settle. The vectors sweep all sixteen codes with directed sign-boundary and equal-operand corners, followed by pseudo-random operands.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  // Operation class chosen by the decoder
  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_ARITH = 2'd1,
    K_LOGIC = 2'd2,
    K_CMP   = 2'd3
  } op_kind_e;

  // Bitwise operation chosen inside the logic class
  typedef enum logic [1:0] {
    L_AND = 2'd0,
    L_OR  = 2'd1,
    L_XOR = 2'd2,
    L_NOR = 2'd3
  } logic_op_e;

  typedef struct packed {
    op_kind_e  kind;
    logic      invert_b;   // adder sees ~b with carry-in 1
    logic_op_e lop;
    logic      cmp_signed;
  } alu_ctrl_t;

  localparam int CODE_W = 4;

endpackage

// File: rtl/flag_alu_decode.sv
module flag_alu_decode
  import flag_alu_pkg::*;
(
  input  logic [CODE_W-1:0] f,
  output alu_ctrl_t         ctrl
);

  always_comb begin
    ctrl            = '0;
    ctrl.kind       = K_NONE;
    ctrl.lop        = L_AND;
    unique case (f)
      4'b0000, 4'b0001: ctrl.kind = K_ARITH;
      4'b0010, 4'b0011: begin
        ctrl.kind     = K_ARITH;
        ctrl.invert_b = 1'b1;
      end
      4'b0100: begin ctrl.kind = K_LOGIC; ctrl.lop = L_AND; end
      4'b0101: begin ctrl.kind = K_LOGIC; ctrl.lop = L_OR;  end
      4'b0110: begin ctrl.kind = K_LOGIC; ctrl.lop = L_XOR; end
      4'b0111: begin ctrl.kind = K_LOGIC; ctrl.lop = L_NOR; end
      4'b1010: begin
        ctrl.kind       = K_CMP;
        ctrl.invert_b   = 1'b1;
        ctrl.cmp_signed = 1'b1;
      end
      4'b1011: begin
        ctrl.kind     = K_CMP;
        ctrl.invert_b = 1'b1;
      end
      default: ctrl.kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             invert_b,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             overflow,
  output logic             lt_signed,
  output logic             lt_unsigned
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  assign b_eff = invert_b ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, invert_b};
  assign sum   = wide[MSB:0];
  assign carry = wide[WIDTH];

  // Same-sign inputs with a sign flip in the sum
  assign overflow = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

  // Valid when invert_b is set (the adder forms a - b)
  assign lt_signed   = sum[MSB] ^ overflow;
  assign lt_unsigned = ~carry;

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_op_e        lop,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    unique case (lop)
      L_AND:   res = a & b;
      L_OR:    res = a | b;
      L_XOR:   res = a ^ b;
      default: res = ~(a | b);
    endcase
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]  a,
  input  logic [WIDTH-1:0]  b,
  input  logic [CODE_W-1:0] f,
  output logic [WIDTH-1:0]  y,
  output logic              cout,
  output logic              ov
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] lres;
  logic             add_c, add_v, lt_s, lt_u, lt_sel;

  flag_alu_decode u_dec (
    .f    (f),
    .ctrl (ctrl)
  );

  flag_alu_adder #(.WIDTH(WIDTH)) u_add (
    .a           (a),
    .b           (b),
    .invert_b    (ctrl.invert_b),
    .sum         (sum),
    .carry       (add_c),
    .overflow    (add_v),
    .lt_signed   (lt_s),
    .lt_unsigned (lt_u)
  );

  flag_alu_logic #(.WIDTH(WIDTH)) u_log (
    .a   (a),
    .b   (b),
    .lop (ctrl.lop),
    .res (lres)
  );

  assign lt_sel = ctrl.cmp_signed ? lt_s : lt_u;

  always_comb begin
    y    = '0;
    cout = 1'b0;
    ov   = 1'b0;
    unique case (ctrl.kind)
      K_ARITH: begin
        y    = sum;
        cout = add_c;
        ov   = add_v;
      end
      K_LOGIC: y = lres;
      K_CMP:   y = {{MSB{1'b0}}, lt_sel};
      default: y = '0;
    endcase
  end

  // Guards on the output selection
  always_comb begin
    if (ctrl.kind == K_LOGIC || ctrl.kind == K_CMP)
      AST_QUIET_FLAGS: assert (!cout && !ov); // R8
    if (ctrl.kind == K_CMP)
      AST_CMP_ONE_BIT: assert (y[MSB:1] == '0); // R6
    if (ctrl.kind == K_NONE)
      AST_UNLISTED_ZERO: assert (y == '0 && !cout && !ov); // R9
    if (ctrl.kind == K_ARITH && ctrl.invert_b)
      AST_SUB_BORROW: assert (cout == (a >= b)); // R3
    if (ctrl.kind == K_ARITH && !ctrl.invert_b && (a[MSB] != b[MSB]))
      AST_MIXED_SIGN_NO_OV: assert (!ov); // R4
    if (f == 4'b0110 && a == b)
      AST_XOR_SELF: assert (y == '0); // R5
  end

endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;

  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [W-1:0] a = '0, b = '0;
  logic [3:0]   f = '0;
  logic [W-1:0] y;
  logic         cout, ov;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  flag_alu #(.WIDTH(W)) uut (
    .a(a), .b(b), .f(f), .y(y), .cout(cout), .ov(ov)
  );

  // Behavioural reference
  longint unsigned mask;
  longint          smax, smin;

  function automatic longint to_s(logic [W-1:0] v);
    longint r = longint'(v);
    if (v[W-1]) r = r - (longint'(1) <<< W);
    return r;
  endfunction

  task automatic check(string req, string what, longint unsigned act, longint unsigned exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s f=%b a=%h b=%h actual=%h expected=%h",
               req, what, f, a, b, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] fc, logic [W-1:0] av, logic [W-1:0] bv);
    longint unsigned ua, ub, s, ey;
    longint          sa, sb, ss;
    logic            ec, ev;
    string           rq;
    @(posedge clk);
    #2;
    f = fc; a = av; b = bv;
    ua = longint'(av); ub = longint'(bv);
    sa = to_s(av); sb = to_s(bv);
    ey = 0; ec = 0; ev = 0; rq = "R9";
    case (fc)
      4'b0000, 4'b0001: begin
        s = ua + ub; ey = s & mask; ec = s[W]; ss = sa + sb;
        ev = (ss > smax) || (ss < smin); rq = "R1";
      end
      4'b0010, 4'b0011: begin
        s = ua + ((~ub) & mask) + 1; ey = s & mask; ec = s[W]; ss = sa - sb;
        ev = (ss > smax) || (ss < smin); rq = "R2";
      end
      4'b0100: begin ey = ua & ub; rq = "R5"; end
      4'b0101: begin ey = ua | ub; rq = "R5"; end
      4'b0110: begin ey = ua ^ ub; rq = "R5"; end
      4'b0111: begin ey = (~(ua | ub)) & mask; rq = "R5"; end
      4'b1010: begin ey = (sa < sb) ? 1 : 0; rq = "R6"; end
      4'b1011: begin ey = (ua < ub) ? 1 : 0; rq = "R7"; end
      default: rq = "R9";
    endcase
    @(negedge clk); // R10: same-cycle result, sampled half a period later
    check(rq, "y", longint'(y), ey);
    check((fc[3:2] == 2'b00) ? "R3" : "R8", "cout", longint'(cout), longint'(ec));
    check((fc[3:2] == 2'b00) ? "R4" : ((rq == "R9") ? "R9" : "R8"), "ov",
          longint'(ov), longint'(ev));
  endtask

  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES = '1;

  initial begin
    mask = (longint'(1) <<< W) - 1;
    smax = (longint'(1) <<< (W-1)) - 1;
    smin = -(longint'(1) <<< (W-1));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: all-zero inputs give all-zero outputs (R1)
    @(negedge clk);
    check("R1", "y", longint'(y), 0);
    check("R3", "cout", longint'(cout), 0);
    check("R4", "ov", longint'(ov), 0);

    // R1 / R3 / R4 corners
    apply(4'b0000, MAXP, 1);      // positive overflow
    apply(4'b0001, MINN, MINN);   // negative overflow, carry
    apply(4'b0000, ONES, 1);      // wrap with carry, no overflow
    apply(4'b0001, 32'h1234, 32'h4321);
    // R2 / R3 / R4 corners
    apply(4'b0010, 5, 5);         // zero, carry 1
    apply(4'b0011, 3, 7);         // borrow, carry 0
    apply(4'b0010, MINN, 1);      // overflow
    apply(4'b0011, MAXP, ONES);   // overflow
    apply(4'b0010, 0, 0);
    // R5 / R8
    apply(4'b0100, 32'hF0F0_1234, 32'h0FF0_FFFF);
    apply(4'b0101, 32'hF0F0_1234, 32'h0FF0_0000);
    apply(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    apply(4'b0111, 0, 0);
    // R6 / R7: sign-sensitive pairs
    apply(4'b1010, ONES, 1);
    apply(4'b1011, ONES, 1);
    apply(4'b1010, MINN, MAXP);
    apply(4'b1011, MINN, MAXP);
    apply(4'b1010, 7, 7);
    apply(4'b1011, 7, 7);
    apply(4'b1010, MAXP, MINN);
    // R9: every unlisted code with busy operands
    apply(4'b1000, ONES, ONES);
    apply(4'b1001, MAXP, 1);
    apply(4'b1100, ONES, 1);
    apply(4'b1101, MINN, MINN);
    apply(4'b1110, 5, 3);
    apply(4'b1111, ONES, 0);
    // Pseudo-random sweep across all codes
    for (int i = 0; i < 3000; i++)
      apply(4'(i % 16), W'($urandom), W'($urandom));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule